// File: doc/BRIEF.md
# Run and Single-Step Clock Controller

This block decides, cycle by cycle, whether a processor under host debug may take its next clock. It holds a run flag, a synchronised copy of the host's run request, and a stop flag. The processor clock enable is high only while the run flag is set and the stop flag is clear. The stop flag is set at an instruction boundary when a single step is requested or an error is reported. It stays set until the host clears it explicitly. Because of this, a run request that reaches the block just after a halt cannot slip through a further instruction.

An optional fine-step mode adds a second halt point at the end of the t1 sub-phase, so a single step stops after t1 and again after t2. The mode request is taken in only while the phase input reads t0. The block also holds the current and delayed task numbers, which the host forces while the processor is halted. A clear level zeroes both. A jam level ORs a supplied byte into them, so the host issues a clear before a jam. Both levels act on every cycle for as long as they are held.

Top module: `rsc_run_step_ctl`

## Requirements
- R1: While reset is low and after it is released, stopped is 1, clk_en is 0 and both task outputs are 0.
- R2: The run flag copies run_req through two flip-flops. A level on run_req applied before clock edge k is seen in the run flag after edge k+1.
- R3: clk_en is 1 exactly when the run flag is 1 and the stop flag is 0, and stopped always shows the stop flag.
- R4: At an edge where the run flag is 1, a halt point is present and step_req or error is 1, the stop flag becomes 1. A halt point is last_phase=1, or phase=1 (t1) while fine mode is latched. Phase encoding: 0=t0, 1=t1, 2=t2.
- R5: Once set, the stop flag holds, whatever run_req does, until an edge with clr_stop=1 and no set condition. Such an edge clears it. Set wins over clear.
- R6: With the stop flag clear, a request for run plus step gives exactly three enabled clocks (t0, t1, t2) before the halt.
- R7: With fine mode latched, a step halts after the t1 clock (two enabled clocks), and the following step halts after the t2 clock.
- R8: fine_req is latched only at an edge where phase=0. Its value at other edges has no effect.
- R9: At an edge with task_clr=1, cur_task and dly_task become 0. This takes priority over jam.
- R10: At an edge with jam=1 and task_clr=0, cur_task becomes cur_task OR jam_word[7:4] and dly_task becomes dly_task OR jam_word[3:0].
- R11: The clear and jam levels act again on every edge while they are held. A held jam with changing data keeps accumulating bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_req | input | 1 | Host run request level (asynchronous) |
| step_req | input | 1 | Host single-step request level |
| clr_stop | input | 1 | Clear the stop flag |
| fine_req | input | 1 | Request a halt after t1 as well as t2 |
| task_clr | input | 1 | Zero both task registers |
| jam | input | 1 | OR jam_word into the task registers |
| jam_word | input | 8 | Upper nibble to the current task, lower nibble to the delayed task |
| last_phase | input | 1 | Final phase of the current instruction |
| phase | input | 2 | Sub-phase of the next clock: 0=t0, 1=t1, 2=t2 |
| error | input | 1 | Error halt request |
| clk_en | output | 1 | Processor clock enable |
| stopped | output | 1 | Stop flag status |
| cur_task | output | 4 | Current task number |
| dly_task | output | 4 | Delayed task number |

## Verification
The stop flag, the fine-mode latch and the task registers respond one edge after their inputs. A change on run_req reaches clk_en only after two edges. The bench drives inputs on the falling edge and steps a reference model on the rising edge, using the same values. It compares every output at the next falling edge, so each comparison covers exactly the edges that have passed. The directed step tests count enabled clocks at falling edges, and the phase input advances only after an edge that was enabled. This lets the count of three (or two in fine mode) be read directly as clocks executed.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam logic [1:0] PH_T0 = 2'd0;
  localparam logic [1:0] PH_T1 = 2'd1;
  localparam logic [1:0] PH_T2 = 2'd2;

  // an edge at which a stop may be taken
  function automatic logic halt_point(input logic last, input logic fine,
                                      input logic [1:0] ph);
    return last | (fine & (ph == PH_T1));
  endfunction

  // next task value: clear wins, jam merges bits in
  function automatic logic [3:0] task_next(input logic [3:0] cur, input logic clr,
                                           input logic jm, input logic [3:0] dat);
    if (clr) return '0;
    if (jm) return cur | dat;
    return cur;
  endfunction
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsc_stop_ctl.sv
module rsc_stop_ctl
  import rsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_q,
  input  logic       step_req,
  input  logic       error,
  input  logic       clr_stop,
  input  logic       fine_req,
  input  logic       last_phase,
  input  logic [1:0] phase,
  output logic       stop_q,
  output logic       fine_q,
  output logic       halt_pt,
  output logic       stop_set
);
  assign halt_pt  = halt_point(last_phase, fine_q, phase);
  assign stop_set = run_q & halt_pt & (step_req | error);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fine_q <= 1'b0;
    else if (phase == PH_T0) fine_q <= fine_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= 1'b1;
    else if (stop_set) stop_q <= 1'b1;
    else if (clr_stop) stop_q <= 1'b0;
  end
endmodule

// File: rtl/rsc_task_regs.sv
module rsc_task_regs
  import rsc_pkg::*;
#(
  parameter int TASK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              task_clr,
  input  logic              jam,
  input  logic [2*TASK_W-1:0] jam_word,
  output logic [TASK_W-1:0] cur_task,
  output logic [TASK_W-1:0] dly_task
);
  logic [TASK_W-1:0] cur_d, dly_d;

  always_comb begin
    cur_d = cur_task;
    dly_d = dly_task;
    if (task_clr) begin
      cur_d = '0;
      dly_d = '0;
    end else if (jam) begin
      cur_d = cur_task | jam_word[2*TASK_W-1:TASK_W];
      dly_d = dly_task | jam_word[TASK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_task <= '0;
      dly_task <= '0;
    end else begin
      cur_task <= cur_d;
      dly_task <= dly_d;
    end
  end
endmodule

// File: rtl/rsc_run_step_ctl.sv
module rsc_run_step_ctl #(
  parameter int TASK_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_req,
  input  logic                step_req,
  input  logic                clr_stop,
  input  logic                fine_req,
  input  logic                task_clr,
  input  logic                jam,
  input  logic [2*TASK_W-1:0] jam_word,
  input  logic                last_phase,
  input  logic [1:0]          phase,
  input  logic                error,
  output logic                clk_en,
  output logic                stopped,
  output logic [TASK_W-1:0]   cur_task,
  output logic [TASK_W-1:0]   dly_task
);
  logic run_q, stop_q, fine_q, halt_pt, stop_set;

  rsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(run_req), .q(run_q));

  rsc_stop_ctl u_stop (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .step_req(step_req),
    .error(error), .clr_stop(clr_stop), .fine_req(fine_req),
    .last_phase(last_phase), .phase(phase), .stop_q(stop_q),
    .fine_q(fine_q), .halt_pt(halt_pt), .stop_set(stop_set));

  rsc_task_regs #(.TASK_W(TASK_W)) u_task (
    .clk(clk), .rst_n(rst_n), .task_clr(task_clr), .jam(jam),
    .jam_word(jam_word), .cur_task(cur_task), .dly_task(dly_task));

  assign clk_en  = run_q & ~stop_q;
  assign stopped = stop_q;
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk #(
  parameter int TASK_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run_req,
  input logic                clr_stop,
  input logic                task_clr,
  input logic                jam,
  input logic [2*TASK_W-1:0] jam_word,
  input logic [1:0]          phase,
  input logic                clk_en,
  input logic                stopped,
  input logic                run_q,
  input logic                fine_q,
  input logic                stop_set,
  input logic [TASK_W-1:0]   cur_task,
  input logic [TASK_W-1:0]   dly_task
);
  // R2
  run_sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(run_req, 2));
  // R3
  stopped_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !clk_en);
  // R4
  stop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_set |=> stopped);
  // R5
  stop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !clr_stop) |=> stopped);
  // R8
  fine_only_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd0) |=> $stable(fine_q));
  // R9
  task_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_clr |=> (cur_task == '0 && dly_task == '0));
  // R10
  jam_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jam && !task_clr) |=>
      ((cur_task & $past(jam_word[2*TASK_W-1:TASK_W])) == $past(jam_word[2*TASK_W-1:TASK_W])));
  // R11
  task_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !task_clr |=> ((dly_task & $past(dly_task)) == $past(dly_task)));
endmodule

bind rsc_run_step_ctl rsc_chk #(.TASK_W(TASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_req(run_req), .clr_stop(clr_stop),
  .task_clr(task_clr), .jam(jam), .jam_word(jam_word), .phase(phase),
  .clk_en(clk_en), .stopped(stopped), .run_q(run_q), .fine_q(fine_q),
  .stop_set(stop_set), .cur_task(cur_task), .dly_task(dly_task));

// File: tb/sim_rsc_run_step_ctl.sv
`timescale 1ns/1ps
module sim_rsc_run_step_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run_req = 0, step_req = 0, clr_stop = 0, fine_req = 0;
  logic task_clr = 0, jam = 0, last_phase = 0, error = 0;
  logic [7:0] jam_word = '0;
  logic [1:0] phase = '0;
  logic clk_en, stopped;
  logic [3:0] cur_task, dly_task;

  int checks = 0, errors = 0;
  bit prev_en = 0;

  // reference model state
  bit m_s1, m_run, m_stop = 1, m_fine;
  logic [3:0] m_cur, m_dly;

  always #2 clk = ~clk;

  rsc_run_step_ctl u0 (.*);

  function automatic bit exp_halt(bit lp, bit fn, logic [1:0] ph);
    return lp || (fn && ph == 2'd1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_run = 0; m_stop = 1; m_fine = 0; m_cur = 0; m_dly = 0;
    end else begin
      bit set_c;
      set_c = m_run && exp_halt(last_phase, m_fine, phase) && (step_req || error);
      if (set_c) m_stop = 1; else if (clr_stop) m_stop = 0;
      m_run = m_s1; m_s1 = run_req;
      if (phase == 2'd0) m_fine = fine_req;
      if (task_clr) begin m_cur = 0; m_dly = 0; end
      else if (jam) begin m_cur = m_cur | jam_word[7:4]; m_dly = m_dly | jam_word[3:0]; end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // next negedge, then advance phase if the last edge was enabled
  task automatic tick();
    @(negedge clk);
    if (prev_en) phase = (phase == 2'd2) ? 2'd0 : phase + 2'd1;
    last_phase = (phase == 2'd2);
    prev_en = clk_en;
  endtask

  task automatic cmp_all();
    chk("R3 clk_en", clk_en, m_run && !m_stop);
    chk("R5 stopped", stopped, m_stop);
    chk("R10 cur_task", cur_task, m_cur);
    chk("R11 dly_task", dly_task, m_dly);
  endtask

  task automatic count_step(output int n);
    n = 0;
    for (int i = 0; i < 12; i++) begin tick(); if (clk_en) n++; end
  endtask

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 stopped", stopped, 1); chk("R1 clk_en", clk_en, 0);
    chk("R1 cur_task", cur_task, 0); chk("R1 dly_task", dly_task, 0);
    rst_n = 1;
    tick();
    chk("R1 stopped after release", stopped, 1);

    // R5: run without clearing stop stays halted
    run_req = 1;
    repeat (6) tick();
    chk("R5 run blocked while stopped", clk_en, 0);
    run_req = 0; repeat (3) tick();
    clr_stop = 1; tick(); clr_stop = 0;
    chk("R5 clr_stop clears", stopped, 0);
    chk("R2 no run yet", clk_en, 0);

    // R2: two-edge sync latency
    run_req = 1; tick();
    chk("R2 one edge", clk_en, 0);
    run_req = 0; step_req = 1; run_req = 1;
    tick();
    chk("R2 two edges", clk_en, 1);
    run_req = 0; step_req = 0; repeat (4) tick();
    // stopped cleanly? run dropped -> no stop set; restore
    clr_stop = 1; tick(); clr_stop = 0;
    while (phase != 2'd0) begin prev_en = 1; tick(); prev_en = 0; end

    // R6: one full step
    prev_en = 0; run_req = 1; step_req = 1;
    count_step(n);
    chk("R6 enabled clocks in step", n, 3);
    chk("R4 halted at end of step", stopped, 1);
    run_req = 0; step_req = 0; tick();
    clr_stop = 1; tick(); clr_stop = 0;

    // R7: fine steps, latched at t0
    fine_req = 1; tick(); tick();
    run_req = 1; step_req = 1;
    count_step(n);
    chk("R7 fine step halts after t1", n, 2);
    chk("R7 phase at fine halt", phase, 2);
    run_req = 0; step_req = 0; tick();
    fine_req = 0;   // R8: phase is t2 here, ignored
    tick();
    clr_stop = 1; tick(); clr_stop = 0;
    run_req = 1; step_req = 1;
    count_step(n);
    chk("R7 second fine step", n, 1);
    run_req = 0; step_req = 0; tick();
    chk("R8 fine latched at t0 only", phase, 0);

    // R4: error halt during free run
    clr_stop = 1; tick(); clr_stop = 0;
    run_req = 1; repeat (8) tick();
    chk("R4 free running", clk_en, 1);
    error = 1;
    while (!last_phase) tick();
    tick(); tick();
    chk("R4 error halt", stopped, 1);
    error = 0; run_req = 0; tick();

    // R9/R10/R11 task forcing
    task_clr = 1; jam = 1; jam_word = 8'hFF; tick();
    chk("R9 clear beats jam", {cur_task, dly_task}, 8'h00);
    task_clr = 0; jam_word = 8'h21; tick();
    chk("R10 jam or", {cur_task, dly_task}, 8'h21);
    jam_word = 8'h84; tick();
    chk("R11 jam accumulates", {cur_task, dly_task}, 8'hA5);
    jam = 0; jam_word = 8'h5A; tick();
    chk("R10 no jam holds", {cur_task, dly_task}, 8'hA5);
    task_clr = 1; tick(); tick();
    chk("R9 clear held", {cur_task, dly_task}, 8'h00);
    task_clr = 0;

    // random phase with full model comparison
    for (int i = 0; i < 3000; i++) begin
      run_req  = ($urandom % 4) != 0;
      step_req = ($urandom % 4) == 0;
      error    = ($urandom % 16) == 0;
      clr_stop = ($urandom % 6) == 0;
      fine_req = ($urandom % 4) == 0;
      task_clr = ($urandom % 8) == 0;
      jam      = ($urandom % 4) == 0;
      jam_word = 8'($urandom);
      tick();
      cmp_all();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule